// File: doc/BRIEF.md
# Interlocked Read Link over a Shared Address/Data Bus

This block joins an I/O-side read master to a memory-side word store across a bus that has no shared clock. Each side runs on its own clock and reset. A read needs only three control wires: a read request, an acknowledge and a data-ready strobe. One set of data lines carries the address out and the read word back. Every edge on a control wire answers an edge from the other side. Each side sees the other side's wires only through two-flop synchronizers, so the two clocks may have any ratio.

On the I/O side, a client hands in addresses and takes back words through two valid/ready streams. A command is accepted in an I/O-clock cycle in which `cmd_valid` and `cmd_ready` are both high. Only one read can be outstanding at a time, so `cmd_ready` stays low until the response has been taken. The response stream obeys back-pressure: once `rsp_valid` is high, it stays high with `rsp_data` unchanged until a cycle in which `rsp_ready` is high. On the memory side, a programmable pause of 0 to 15 cycles stands in for a slow store before the word is returned.

The three control wires, the data lines and both drive enables are brought out as ports so the link can be watched.

Top module: `hs_read_link`

## Requirements
- R1: While either reset is held, and right after both are released, `cmd_ready` is 1, `rsp_valid` is 0, `line_read_req`, `line_ack` and `line_data_rdy` are 0, and `io_drive` and `mem_drive` are 0.
- R2: A command is taken in an I/O-clock cycle with `cmd_valid` and `cmd_ready` both high. From that cycle until the response is accepted, `cmd_ready` is 0 and `cmd_valid` has no effect.
- R3: The I/O side raises `line_read_req` and `io_drive` together, with the accepted address zero-extended on `line_data`. The address stays on `line_data` for as long as the request is high.
- R4: Written as (read_req, ack, data_rdy), a read steps the control wires through exactly these states: 100, 110, 010, 000, 001, 011, 010, 000. Each step is taken only after the previous one has been seen through the synchronizer.
- R5: The memory side drives `line_data` only while `line_data_rdy` is high, and during that time the lines hold the word read at the captured address.
- R6: `io_drive` and `mem_drive` are never high at the same time.
- R7: `line_data_rdy` rises exactly `mem_latency` + 4 memory-clock cycles after the first fall of `line_ack` within a read. `mem_latency` must be held stable while a read is in progress.
- R8: The word stored at address i is (37*i + 90) mod 2^DW. After a read of address i, `rsp_data` carries that word.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values. In the cycle after `rsp_ready` is seen high, `rsp_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O-side clock |
| rst_io_n | input | 1 | I/O-side asynchronous reset, active low |
| clk_mem | input | 1 | Memory-side clock |
| rst_mem_n | input | 1 | Memory-side asynchronous reset, active low |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Link idle, command can be taken |
| cmd_addr | input | AW | Address to read |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Client takes the word |
| rsp_data | output | DW | Read word |
| mem_latency | input | 4 | Memory-side pause in cycles, 0 to 15 |
| line_read_req | output | 1 | Read request wire |
| line_ack | output | 1 | Acknowledge wire (wired-OR of both sides) |
| line_data_rdy | output | 1 | Data-ready wire |
| line_data | output | max(AW,DW) | Shared address/data lines |
| io_drive | output | 1 | I/O side drives the data lines |
| mem_drive | output | 1 | Memory side drives the data lines |

## Verification
The assertions take for granted that both resets are released together, that `mem_latency` changes only while no read is in progress, and that the response client keeps `rsp_ready` low for as long as it wants the word held. The cross-domain properties, such as the acknowledge rising only against a live request, depend on the protocol's interlock and not on any clock ratio. The stimulus therefore runs the two clocks at unrelated periods. It writes a new `mem_latency` only after the previous response has been accepted, and it drives every input on the falling edge of its own clock.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_ASK,
    RQ_WAIT,
    RQ_ACK,
    RQ_SETTLE,
    RQ_HAND
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK,
    RS_GAP,
    RS_WAIT,
    RS_DRIVE,
    RS_DONE
  } rs_state_t;

  // Content of word i in the memory model.
  function automatic logic [31:0] seed_word(int unsigned i);
    return 32'(i * 37 + 90);
  endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_word_store.sv
module hs_word_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= DW'(hs_pkg::seed_word(i));
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= cells[i];
      end
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          ack_line,
  input  logic          drdy_line,
  input  logic [DW-1:0] bus_in,
  output logic          read_req,
  output logic          ack_out,
  output logic          drive,
  output logic [AW-1:0] addr_out
);
  rq_state_t     state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          ack_s;
  logic          drdy_s;

  hs_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ack_line, drdy_line}),
    .q     ({ack_s, drdy_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RQ_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        RQ_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          state  <= RQ_ASK;
        end
        RQ_ASK: if (ack_s) state <= RQ_WAIT;
        RQ_WAIT: if (drdy_s) begin
          data_q <= bus_in;
          state  <= RQ_ACK;
        end
        RQ_ACK: if (!drdy_s) state <= RQ_SETTLE;
        RQ_SETTLE: if (!ack_s) state <= RQ_HAND;
        RQ_HAND: if (rsp_ready) state <= RQ_IDLE;
        default: state <= RQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == RQ_IDLE);
  assign read_req  = (state == RQ_ASK);
  assign drive     = (state == RQ_ASK);
  assign ack_out   = (state == RQ_ACK);
  assign rsp_valid = (state == RQ_HAND);
  assign rsp_data  = data_q;
  assign addr_out  = addr_q;
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] latency,
  input  logic          rreq_line,
  input  logic          ack_line,
  input  logic [AW-1:0] bus_in,
  output logic          ack_out,
  output logic          drdy,
  output logic          drive,
  output logic [DW-1:0] data_out
);
  rs_state_t     state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [LW-1:0] cnt;
  logic          rreq_s;
  logic          ack_s;
  logic [DW-1:0] word;

  hs_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rreq_line, ack_line}),
    .q     ({rreq_s, ack_s})
  );

  hs_word_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_data (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        RS_IDLE: if (rreq_s) begin
          addr_q <= bus_in;
          state  <= RS_ACK;
        end
        RS_ACK: if (!rreq_s) state <= RS_GAP;
        // Own acknowledge must be seen low before the data phase,
        // so a later acknowledge is known to come from the I/O side.
        RS_GAP: if (!ack_s) begin
          cnt   <= '0;
          state <= RS_WAIT;
        end
        RS_WAIT: begin
          if (cnt == latency) begin
            data_q <= word;
            state  <= RS_DRIVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_DRIVE: if (ack_s) state <= RS_DONE;
        RS_DONE: if (!ack_s) state <= RS_IDLE;
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign ack_out  = (state == RS_ACK);
  assign drdy     = (state == RS_DRIVE);
  assign drive    = (state == RS_DRIVE);
  assign data_out = data_q;
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic                           clk_io,
  input  logic                           rst_io_n,
  input  logic                           clk_mem,
  input  logic                           rst_mem_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [AW-1:0]                  cmd_addr,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DW-1:0]                  rsp_data,
  input  logic [3:0]                     mem_latency,
  output logic                           line_read_req,
  output logic                           line_ack,
  output logic                           line_data_rdy,
  output logic [((AW > DW) ? AW : DW)-1:0] line_data,
  output logic                           io_drive,
  output logic                           mem_drive
);
  localparam int BW = (AW > DW) ? AW : DW;
  localparam int LW = 4;

  logic          ack_io_w;
  logic          ack_mem_w;
  logic [AW-1:0] io_addr_w;
  logic [DW-1:0] mem_data_w;

  // Wired-OR acknowledge and a resolved view of the shared lines.
  assign line_ack  = ack_io_w | ack_mem_w;
  assign line_data = io_drive  ? BW'(io_addr_w)  :
                     mem_drive ? BW'(mem_data_w) : '0;

  hs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk_io),
    .rst_n     (rst_io_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .ack_line  (line_ack),
    .drdy_line (line_data_rdy),
    .bus_in    (line_data[DW-1:0]),
    .read_req  (line_read_req),
    .ack_out   (ack_io_w),
    .drive     (io_drive),
    .addr_out  (io_addr_w)
  );

  hs_responder #(.AW(AW), .DW(DW), .LW(LW)) u_rsp (
    .clk       (clk_mem),
    .rst_n     (rst_mem_n),
    .latency   (mem_latency),
    .rreq_line (line_read_req),
    .ack_line  (line_ack),
    .bus_in    (line_data[AW-1:0]),
    .ack_out   (ack_mem_w),
    .drdy      (line_data_rdy),
    .drive     (mem_drive),
    .data_out  (mem_data_w)
  );
endmodule

// File: rtl/hs_read_checker.sv
module hs_read_checker #(
  parameter int DW = 8
) (
  input logic          clk_io,
  input logic          rst_io_n,
  input logic          clk_mem,
  input logic          rst_mem_n,
  input logic          read_req,
  input logic          ack_io,
  input logic          ack_mem,
  input logic          data_rdy,
  input logic          io_drive,
  input logic          mem_drive,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data
);
  AST_NO_OVERLAP_MEM: assert property (@(posedge clk_mem) disable iff (!rst_mem_n) !(io_drive && mem_drive)); // R6
  AST_NO_OVERLAP_IO: assert property (@(posedge clk_io) disable iff (!rst_io_n) !(io_drive && mem_drive)); // R6
  AST_ACK_ON_LIVE_REQ: assert property (@(posedge clk_mem) disable iff (!rst_mem_n) $rose(ack_mem) |-> read_req); // R4
  AST_DRDY_AFTER_REQ_LOW: assert property (@(posedge clk_mem) disable iff (!rst_mem_n) data_rdy |-> !read_req); // R4
  AST_IO_ACK_ON_DRDY: assert property (@(posedge clk_io) disable iff (!rst_io_n) $rose(ack_io) |-> data_rdy); // R4
  AST_REQ_HAS_BUS: assert property (@(posedge clk_io) disable iff (!rst_io_n) read_req |-> io_drive && !mem_drive); // R3
  AST_DRDY_HAS_BUS: assert property (@(posedge clk_mem) disable iff (!rst_mem_n) data_rdy |-> mem_drive && !io_drive); // R5
  AST_RSP_QUIET_BUS: assert property (@(posedge clk_io) disable iff (!rst_io_n) rsp_valid |-> !data_rdy && !mem_drive); // R5
  AST_RSP_HELD: assert property (@(posedge clk_io) disable iff (!rst_io_n) rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
endmodule

bind hs_read_link hs_read_checker #(.DW(DW)) u_chk (
  .clk_io    (clk_io),
  .rst_io_n  (rst_io_n),
  .clk_mem   (clk_mem),
  .rst_mem_n (rst_mem_n),
  .read_req  (line_read_req),
  .ack_io    (ack_io_w),
  .ack_mem   (ack_mem_w),
  .data_rdy  (line_data_rdy),
  .io_drive  (io_drive),
  .mem_drive (mem_drive),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/sim_hs_read_link.sv
`timescale 1ns/1ps
module sim_hs_read_link;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_PERIOD = 14;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int BW = (AW > DW) ? AW : DW;

  logic          clk_io = 0, clk_mem = 0;
  logic          rst_io_n = 0, rst_mem_n = 0;
  logic          cmd_valid = 0, rsp_ready = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0]    mem_latency = '0;
  logic          cmd_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          line_read_req, line_ack, line_data_rdy;
  logic [BW-1:0] line_data;
  logic          io_drive, mem_drive;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_io = ~clk_io;
  always #(MEM_PERIOD/2) clk_mem = ~clk_mem;

  hs_read_link #(.AW(AW), .DW(DW)) u0 (
    .clk_io(clk_io), .rst_io_n(rst_io_n), .clk_mem(clk_mem), .rst_mem_n(rst_mem_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_latency(mem_latency), .line_read_req(line_read_req), .line_ack(line_ack),
    .line_data_rdy(line_data_rdy), .line_data(line_data),
    .io_drive(io_drive), .mem_drive(mem_drive)
  );

  // Line monitor
  logic [2:0] log_st [16];
  int         log_n = 0;
  longint     t_fall = 0, t_rise = 0;
  logic [BW-1:0] seen_addr, seen_data;
  bit         overlap = 0;

  always @(line_read_req or line_ack or line_data_rdy) begin
    if (log_n < 16) log_st[log_n] = {line_read_req, line_ack, line_data_rdy};
    log_n++;
    if (log_n == 4) t_fall = $time;
    if (log_n == 5) t_rise = $time;
  end
  always @(posedge line_read_req) begin #1; seen_addr = line_data; end
  always @(posedge line_data_rdy) begin #1; seen_data = line_data; end
  always @(io_drive or mem_drive) if (io_drive && mem_drive) overlap = 1;

  function automatic logic [DW-1:0] word_of(int a);
    return DW'(a * 37 + 90);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_read(int addr, int lat, int hold);
    logic [DW-1:0] exp = word_of(addr);
    logic [DW-1:0] first;
    logic [2:0] seq [8] = '{3'b100, 3'b110, 3'b010, 3'b000, 3'b001, 3'b011, 3'b010, 3'b000};
    int guard = 0;
    bit seq_ok = 1;
    mem_latency = 4'(lat);
    overlap = 0;
    log_n = 0;
    while (!cmd_ready && guard < 1000) begin @(negedge clk_io); guard++; end
    @(negedge clk_io);
    cmd_valid = 1; cmd_addr = AW'(addr);
    @(negedge clk_io);
    cmd_valid = 0;
    cmd_addr = AW'(addr ^ 5);
    check(!cmd_ready, "R2", "cmd_ready after accept", cmd_ready, 0);
    guard = 0;
    while (!rsp_valid && guard < 2000) begin
      @(negedge clk_io); guard++;
      if (guard == 3) begin
        cmd_valid = 1;  // R2: ignored while busy
      end
    end
    cmd_valid = 0;
    check(rsp_valid, "R9", "rsp_valid arrives", rsp_valid, 1);
    first = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk_io);
      check(rsp_valid && rsp_data == first && !cmd_ready, "R9", "held under back-pressure",
            rsp_data, first);
    end
    check(rsp_data == exp, "R8", "rsp_data", rsp_data, exp);
    rsp_ready = 1;
    @(negedge clk_io);
    rsp_ready = 0;
    check(!rsp_valid && cmd_ready, "R9", "release after ready", {rsp_valid, cmd_ready}, 1);
    check(log_n == 8, "R4", "line state count", log_n, 8);
    for (int k = 0; k < 8; k++) if (k >= log_n || log_st[k] != seq[k]) seq_ok = 0;
    check(seq_ok, "R4", "line state order", seq_ok, 1);
    check(seen_addr == BW'(addr), "R3", "address on lines", seen_addr, addr);
    check(seen_data == BW'(exp), "R5", "word on lines", seen_data, exp);
    check((t_rise - t_fall) == longint'((lat + 4) * MEM_PERIOD), "R7", "latency gap ns",
          t_rise - t_fall, (lat + 4) * MEM_PERIOD);
    check(!overlap, "R6", "drive overlap", overlap, 0);
  endtask

  task automatic t_reset_state();
    check(cmd_ready && !rsp_valid, "R1", "stream flags", {cmd_ready, rsp_valid}, 2);
    check({line_read_req, line_ack, line_data_rdy} == 3'b000, "R1", "control lines",
          {line_read_req, line_ack, line_data_rdy}, 0);
    check(!io_drive && !mem_drive, "R1", "drive enables", {io_drive, mem_drive}, 0);
  endtask

  task automatic t_single();        do_read(5, 3, 0);  endtask
  task automatic t_zero_latency();  do_read(63, 0, 0); endtask
  task automatic t_max_latency();   do_read(0, 15, 0); endtask
  task automatic t_backpressure();  do_read(42, 2, 7); endtask
  task automatic t_sweep();
    do_read(17, 1, 1);
    do_read(33, 9, 0);
    do_read(1, 6, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_io);
    t_reset_state();
    #(MEM_PERIOD * 3);
    @(negedge clk_io);
    rst_io_n = 1; rst_mem_n = 1;
    repeat (3) @(negedge clk_io);
    t_reset_state();
    t_single();
    t_zero_latency();
    t_max_latency();
    t_backpressure();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule